// File: doc/BRIEF.md
# Debug Down-Counter with Breakpoint Compare

This block holds one debug count register that serves three jobs, picked by a two-bit mode input. It counts down the bytes moved by debug memory or register transfers and stops at zero, raising a done flag. It measures elapsed execution clocks by loading all ones and counting down while the CPU runs. It also acts as a temporary breakpoint: the stored value is held and compared with the program counter, and a one-cycle break request is raised before the instruction at the matching address executes. The counter only ever counts down. Every host read returns the bitwise complement of the stored value, so a cycle measurement reads back as an up-count of elapsed clocks.

A host talks to the block through a byte-wide command stream and a byte-wide response stream, both valid/ready. A byte moves only on a cycle where valid and ready are both high. The command side drops `cmd_ready` while a response is pending. The response side holds `rsp_valid` and `rsp_data` steady until `rsp_ready` takes the byte. Command codes are 00h (revision), 01h (write the counter, followed by two data bytes, high byte first), 02h (status) and 03h (read the counter, answered by two inverted bytes, high byte first). Writing and reading the counter are allowed only in debug mode. Revision and status are answered in any mode.

Top module: `dbg_count_brk`

## Requirements
- R1: Command 03h accepted while `dbg_mode` is high returns two response bytes, the complement of the counter's high byte and then of its low byte, taken in the cycle the command byte is accepted. Accepted while `dbg_mode` is low, it returns two 00h bytes.
- R2: Command 01h is followed by two data bytes, high then low. It loads the counter when the second data byte is accepted, but only if `dbg_mode` was high when the 01h byte was accepted. Otherwise both data bytes are consumed and the counter is unchanged.
- R3: Command 00h returns one byte equal to parameter REV (default 5Ah). Command 02h returns one byte {6'b0, byte_done, dbg_mode}. Both are answered whatever the state of `dbg_mode`.
- R4: After reset the counter is 0000h. It never increases except by a host write or by entering cycle mode.
- R5: Cycle mode (`mode_sel`=10b): in the first cycle `mode_sel` becomes 10b, the counter loads FFFFh. After that it decrements once per clock while `cpu_run` is high, and holds at 0000h.
- R6: Byte mode (`mode_sel`=01b): the counter decrements once per clock with `xfer_stb` high and stops at 0000h. `byte_done` is high exactly while the mode is 01b and the counter is 0000h.
- R7: Break mode (`mode_sel`=11b): the counter holds its value. `brk_req` is a one-cycle pulse when `cpu_run` is high and `pc` equals the counter. It fires again only after the match has gone away. It is never high in any other mode or while `cpu_run` is low.
- R8: Hold mode (`mode_sel`=00b): the counter keeps its value, including the residual left by a byte transfer.
- R9: `cmd_ready` is low while any response byte is pending. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged.
- R10: A host write that completes in the same cycle as a decrement or a cycle-mode entry load wins; the written value is stored.
- R11: A command byte other than 00h–03h is consumed and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Core is halted in debug mode |
| cpu_run | input | 1 | CPU is executing instructions |
| mode_sel | input | 2 | 00 hold, 01 byte count, 10 cycle count, 11 breakpoint |
| xfer_stb | input | 1 | One debug transfer byte moved this cycle |
| pc | input | 16 | CPU program counter of the next instruction |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte can be accepted |
| cmd_data | input | 8 | Command or data byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Host takes the response byte |
| rsp_data | output | 8 | Response byte |
| brk_req | output | 1 | One-cycle break request |
| byte_done | output | 1 | Byte count exhausted |

## Verification
The counter is driven through each mode in turn. Byte strobes run past zero, which separates a saturating counter from a wrapping one. Cycle runs with `cpu_run` toggling separate counting per run cycle from counting every clock. A program counter swept through the stored value and then held on it separates a single pulse from a level, and dropping `cpu_run` tests the pulse gating. Reads and writes issued with `dbg_mode` both high and low, a response stalled by `rsp_ready`, a write landing on a strobe cycle and an unknown opcode test the inversion, the mode gating, the back-pressure rules and the write priority.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_BYTES = 2'b01,
    MODE_CYCLE = 2'b10,
    MODE_BREAK = 2'b11
  } cnt_mode_e;

  localparam logic [7:0] OP_REVISION = 8'h00;
  localparam logic [7:0] OP_WRITE    = 8'h01;
  localparam logic [7:0] OP_STATUS   = 8'h02;
  localparam logic [7:0] OP_READ     = 8'h03;

  typedef enum logic [1:0] {
    PS_CMD  = 2'b00,
    PS_DATA = 2'b01,
    PS_RSP  = 2'b10
  } port_state_e;
endpackage

// File: rtl/dbgc_cmd_port.sv
module dbgc_cmd_port
  import dbgc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [7:0] REV = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_mode,
  input  logic [7:0]       status,
  input  logic [CNT_W-1:0] count,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             load_en,
  output logic [CNT_W-1:0] load_val
);
  localparam int NBYTES = CNT_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int LEFT_W = $clog2(NBYTES + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NBYTES - 1);
  localparam logic [LEFT_W-1:0] ONE_LEFT = LEFT_W'(1);

  port_state_e        st;
  logic               wr_ok;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   acc;
  logic [CNT_W-1:0]   rsp_sh;
  logic [LEFT_W-1:0]  rsp_left;
  logic               cmd_fire, rsp_fire;
  logic [CNT_W-1:0]   acc_nxt;

  assign cmd_ready = (st != PS_RSP);
  assign rsp_valid = (st == PS_RSP);
  assign rsp_data  = rsp_sh[CNT_W-1 -: 8];
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign acc_nxt   = {acc[CNT_W-9:0], cmd_data};
  assign load_val  = acc_nxt;
  assign load_en   = (st == PS_DATA) && cmd_fire && (idx == LAST_IDX) && wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_CMD;
      wr_ok    <= 1'b0;
      idx      <= '0;
      acc      <= '0;
      rsp_sh   <= '0;
      rsp_left <= '0;
    end else begin
      unique case (st)
        PS_CMD: if (cmd_fire) begin
          unique case (cmd_data)
            OP_REVISION: begin
              rsp_sh   <= {REV, {(CNT_W-8){1'b0}}};
              rsp_left <= ONE_LEFT;
              st       <= PS_RSP;
            end
            OP_STATUS: begin
              rsp_sh   <= {status, {(CNT_W-8){1'b0}}};
              rsp_left <= ONE_LEFT;
              st       <= PS_RSP;
            end
            OP_READ: begin
              rsp_sh   <= dbg_mode ? ~count : '0;
              rsp_left <= LEFT_W'(NBYTES);
              st       <= PS_RSP;
            end
            OP_WRITE: begin
              wr_ok <= dbg_mode;
              idx   <= '0;
              st    <= PS_DATA;
            end
            default: ;
          endcase
        end
        PS_DATA: if (cmd_fire) begin
          acc <= acc_nxt;
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) st <= PS_CMD;
        end
        PS_RSP: if (rsp_fire) begin
          rsp_sh   <= {rsp_sh[CNT_W-9:0], 8'h00};
          rsp_left <= rsp_left - 1'b1;
          if (rsp_left == ONE_LEFT) st <= PS_CMD;
        end
        default: st <= PS_CMD;
      endcase
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9
  AST_NO_CMD_DURING_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R9
endmodule

// File: rtl/dbgc_counter.sv
module dbgc_counter
  import dbgc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode,
  input  logic             cpu_run,
  input  logic             xfer_stb,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             byte_done
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  cnt_mode_e mode_q;
  logic      at_zero, cyc_entry, dec_en;

  assign at_zero   = (count == '0);
  assign cyc_entry = (mode == MODE_CYCLE) && (mode_q != MODE_CYCLE);
  assign byte_done = (mode == MODE_BYTES) && at_zero;

  always_comb begin
    unique case (mode)
      MODE_BYTES: dec_en = xfer_stb && !at_zero;
      MODE_CYCLE: dec_en = cpu_run && !at_zero;
      default:    dec_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      mode_q <= MODE_HOLD;
    end else begin
      mode_q <= mode;
      if (load_en)        count <= load_val;
      else if (cyc_entry) count <= ALL_ONES;
      else if (dec_en)    count <= count - 1'b1;
    end
  end

  AST_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !cyc_entry |=> count <= $past(count)); // R4
  AST_BYTE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_BYTES && at_zero && !load_en |=> count == '0); // R6
  AST_HOLD_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD || mode == MODE_BREAK) && !load_en |=> $stable(count)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count == $past(load_val)); // R10
endmodule

// File: rtl/dbgc_brk_match.sv
module dbgc_brk_match
  import dbgc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode,
  input  logic             cpu_run,
  input  logic [CNT_W-1:0] pc,
  input  logic [CNT_W-1:0] count,
  output logic             brk_req
);
  logic hit, hit_q;

  assign hit     = (mode == MODE_BREAK) && cpu_run && (pc == count);
  assign brk_req = hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req); // R7
  AST_BRK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> cpu_run && mode == MODE_BREAK); // R7
endmodule

// File: rtl/dbg_count_brk.sv
module dbg_count_brk
  import dbgc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [7:0] REV = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_mode,
  input  logic             cpu_run,
  input  logic [1:0]       mode_sel,
  input  logic             xfer_stb,
  input  logic [CNT_W-1:0] pc,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             brk_req,
  output logic             byte_done
);
  cnt_mode_e        mode;
  logic [CNT_W-1:0] count, load_val;
  logic             load_en;
  logic [7:0]       status;

  assign mode   = cnt_mode_e'(mode_sel);
  assign status = {6'b0, byte_done, dbg_mode};

  dbgc_cmd_port #(.CNT_W(CNT_W), .REV(REV)) u_port (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .status(status),
    .count(count), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .load_en(load_en), .load_val(load_val)
  );

  dbgc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cpu_run(cpu_run),
    .xfer_stb(xfer_stb), .load_en(load_en), .load_val(load_val),
    .count(count), .byte_done(byte_done)
  );

  dbgc_brk_match #(.CNT_W(CNT_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cpu_run(cpu_run),
    .pc(pc), .count(count), .brk_req(brk_req)
  );
endmodule

// File: tb/test_dbg_count_brk.sv
`timescale 1ns/1ps
module test_dbg_count_brk;
  localparam logic [7:0] REV = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic dbg_mode = 0, cpu_run = 0, xfer_stb = 0;
  logic [1:0] mode_sel = 2'b00;
  logic [15:0] pc = '0;
  logic cmd_valid = 0, rsp_ready = 1;
  logic [7:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, brk_req, byte_done;
  logic [7:0] rsp_data;

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  dbg_count_brk #(.CNT_W(16), .REV(REV)) i_dbg_count_brk (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .cpu_run(cpu_run),
    .mode_sel(mode_sel), .xfer_stb(xfer_stb), .pc(pc),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .brk_req(brk_req), .byte_done(byte_done)
  );

  // Reference model: behavioural state updated on each rising edge.
  int m_cnt, m_modeq, m_matchq, m_st, m_ok, m_idx, m_acc;
  byte unsigned rq[$];
  string tq[$];

  task automatic push_rsp(input int b, input string t);
    rq.push_back(8'(b)); tq.push_back(t);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_modeq = 0; m_matchq = 0; m_st = 0; m_ok = 0; m_idx = 0; m_acc = 0;
      rq.delete(); tq.delete();
    end else begin
      bit fc, fr, ld;
      int nxt;
      fc = cmd_valid && (rq.size() == 0);
      fr = rsp_ready && (rq.size() > 0);
      ld = 0;
      nxt = m_cnt;
      if (fr) begin void'(rq.pop_front()); void'(tq.pop_front()); end
      if (fc) begin
        if (m_st == 0) begin
          case (cmd_data)
            8'h00: push_rsp(REV, "R3");
            8'h02: push_rsp({(mode_sel == 2'b01 && m_cnt == 0), dbg_mode}, "R3");
            8'h03: if (dbg_mode) begin
                     push_rsp(~(m_cnt >> 8), cur_tag); push_rsp(~m_cnt, cur_tag);
                   end else begin
                     push_rsp(0, cur_tag); push_rsp(0, cur_tag);
                   end
            8'h01: begin m_st = 1; m_ok = dbg_mode; m_idx = 0; end
            default: ;
          endcase
        end else begin
          m_acc = ((m_acc << 8) | cmd_data) & 16'hFFFF;
          m_idx++;
          if (m_idx == 2) begin m_st = 0; ld = m_ok; end
        end
      end
      m_matchq = (mode_sel == 2'b11) && cpu_run && (pc == m_cnt);
      if (ld) nxt = m_acc;
      else if (mode_sel == 2'b10 && m_modeq != 2) nxt = 16'hFFFF;
      else if (mode_sel == 2'b01 && xfer_stb && m_cnt > 0) nxt = m_cnt - 1;
      else if (mode_sel == 2'b10 && cpu_run && m_cnt > 0) nxt = m_cnt - 1;
      m_cnt = nxt;
      m_modeq = mode_sel;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the rising edge.
  always @(negedge clk) if (rst_n) begin
    bit e_brk;
    e_brk = (mode_sel == 2'b11) && cpu_run && (pc == m_cnt[15:0]) && !m_matchq;
    chk("R9 cmd_ready", cmd_ready, rq.size() == 0);
    chk("R9 rsp_valid", rsp_valid, rq.size() > 0);
    if (rq.size() > 0) chk({tq[0], " rsp_data"}, rsp_data, rq[0]);
    chk("R7 brk_req", brk_req, e_brk);
    chk("R6 byte_done", byte_done, (mode_sel == 2'b01) && (m_cnt == 0));
  end

  task automatic send(input logic [7:0] b);
    bit ok;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_data = b;
    do begin
      @(negedge clk); ok = cmd_ready;
      @(posedge clk);
    end while (!ok);
    #1 cmd_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr16(input logic [15:0] v);
    send(8'h01); send(v[15:8]); send(v[7:0]);
  endtask

  task automatic rd16(input string tag);
    cur_tag = tag; send(8'h03); settle(3);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    settle(3);
    // R4: reset state before release
    chk("R4 reset rsp_valid", rsp_valid, 0);
    chk("R4 reset brk_req", brk_req, 0);
    rst_n = 1;
    settle(2);
    chk("R4 reset cmd_ready", cmd_ready, 1);

    // R3: revision and status outside debug mode
    send(8'h00); settle(2);
    send(8'h02); settle(2);
    // R1: read refused outside debug mode -> 00 00
    rd16("R1");
    // R2: write outside debug mode ignored, then read in debug mode shows FFFF
    wr16(16'h1234);
    dbg_mode = 1; settle(1);
    rd16("R2");
    // R11: unknown opcode consumed, no response
    send(8'h7F); settle(2);
    chk("R11 no response", rsp_valid, 0);
    // R1/R2: write then read inverted
    wr16(16'h1234); rd16("R1");
    send(8'h02); settle(2);

    // R6: byte mode, strobes past zero
    wr16(16'h0003);
    mode_sel = 2'b01;
    repeat (5) begin xfer_stb = 1; settle(1); end
    xfer_stb = 0; settle(1);
    chk("R6 done at zero", byte_done, 1);
    send(8'h02); settle(2);
    // R8: residual held in hold mode
    wr16(16'h0009); mode_sel = 2'b01;
    repeat (4) begin xfer_stb = 1; settle(1); xfer_stb = 0; settle(1); end
    mode_sel = 2'b00; settle(3);
    rd16("R8");

    // R10: write completing while strobe is active
    mode_sel = 2'b01; xfer_stb = 1;
    wr16(16'h0100);
    xfer_stb = 0; rd16("R10");

    // R5: cycle mode with run toggling, then past zero
    mode_sel = 2'b10; settle(1);
    for (int i = 0; i < 12; i++) begin cpu_run = i[0]; settle(1); end
    cpu_run = 0; rd16("R5");
    wr16(16'h0004); cpu_run = 1; settle(8); cpu_run = 0;
    rd16("R5");
    // R10: write lands on cycle-mode entry
    mode_sel = 2'b00; settle(1);
    send(8'h01); send(8'h00);
    @(posedge clk); #1; cmd_valid = 1; cmd_data = 8'h22; mode_sel = 2'b10;
    @(posedge clk); #1; cmd_valid = 0;
    rd16("R10");

    // R7: breakpoint compare
    mode_sel = 2'b00; settle(1);
    wr16(16'h0040);
    mode_sel = 2'b11; dbg_mode = 0; cpu_run = 1;
    for (int a = 16'h3E; a <= 16'h42; a++) begin pc = 16'(a); settle(1); end
    pc = 16'h0040; settle(4);
    pc = 16'h0041; settle(1);
    pc = 16'h0040; settle(2);
    cpu_run = 0; pc = 16'h0041; settle(1); pc = 16'h0040; settle(3);
    chk("R7 no pulse when halted", brk_req, 0);
    dbg_mode = 1; rd16("R7");
    mode_sel = 2'b00; pc = '0;

    // R9: back-pressure on response
    rsp_ready = 0;
    cur_tag = "R9"; send(8'h03);
    settle(6);
    chk("R9 stalled valid", rsp_valid, 1);
    rsp_ready = 1; settle(4);
    rsp_ready = 0; send(8'h00); settle(3);
    rsp_ready = 1; settle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule